// File: doc/BRIEF.md
# Traffic Class to Virtual Channel Egress Arbiter

This block decides which ingress port may send its next packet onto a shared egress link. Each port raises a request tagged with a 3-bit traffic class, values 0 to 7. An 8-bit class map register places every class on one of two virtual channels. Inside each channel, a round-robin arbiter chooses among the ports whose requests land on that channel. A second arbiter then chooses the channel that gets the link. The winning port is presented as a grant with a valid/ready handshake toward the link.

Each channel owns a credit counter. The counter reflects buffer space that the receiver has advertised for that channel. A channel with no credit cannot win. Each accepted grant uses one credit. A credit-return strobe per channel adds back an amount chosen by the caller. The grant is combinational from the current requests and state. All state changes happen only at the clock edge.

Top module: `tc_vc_egress_arb`

## Requirements
- R1: After reset, the class map holds 0xF8, both credit counters are 0, and both round-robin pointers are 0. With no credit, `gnt_valid` stays low even when every port requests.
- R2: A request from port p with class t belongs to channel `map[t]`, where bit t of the map selects the channel: 0 means channel 0 and 1 means channel 1. Under the reset map, classes 0 to 2 use channel 0 and classes 3 to 7 use channel 1.
- R3: A map write (`map_wr_en` high) changes the mapping starting in the cycle after the write. In the write cycle, the old mapping still applies.
- R4: Within a channel, the winner is the first requesting port found by searching upward from that channel's pointer, wrapping modulo NUM_PORTS. On an accepted grant, that channel's pointer moves to the winner plus one.
- R5: When no handshake happens (`gnt_valid` and `gnt_ready` not both high), pointers and credits do not change, except that a credit return still adds its amount.
- R6: When both channels are eligible, channel 1 wins.
- R7: A channel is eligible only if it has at least one request and its credit count is non-zero. If channel 1 has no credit, channel 0 may win.
- R8: An accepted grant lowers the granted channel's credit by one. A return adds `crd_ret_amt` for that channel. When both happen in the same cycle, both take effect.
- R9: A credit counter saturates at 2^CREDIT_W-1 instead of wrapping.
- R10: With no eligible channel, `gnt_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Per-port packet request |
| req_tc | input | 3*NUM_PORTS | Per-port traffic class; port p uses bits [3p+2:3p] |
| map_wr_en | input | 1 | Write strobe for the class map |
| map_wr_data | input | 8 | New class map; bit t is the channel of class t |
| crd_ret_en | input | 2 | Per-channel credit return strobe |
| crd_ret_amt | input | 2*RET_W | Per-channel credit return amount; channel v uses bits [RET_W*v +: RET_W] |
| gnt_ready | input | 1 | Link accepts the grant this cycle |
| gnt_valid | output | 1 | A grant is offered |
| gnt_port | output | $clog2(NUM_PORTS) | Index of the winning port |
| gnt_vc | output | 1 | Channel of the winning port |

## Verification
Two events can land on the same channel's counter in one cycle: a credit return and an accepted grant. The bench provokes this by driving a return strobe in a cycle where it also holds `gnt_ready` high with a request pending on that channel. It then judges the result by draining the channel and counting how many further grants are offered. A class map write that arrives while requests on the changed classes are pending also meets the arbitration in the same cycle. The bench checks that the old channel choice holds in the write cycle and that the new one applies in the next.

// File: rtl/tc_vc_egress_arb.sv
module tc_vc_egress_arb #(
  parameter int NUM_PORTS = 4,
  parameter int CREDIT_W  = 6,
  parameter int RET_W     = 4,
  parameter logic [7:0] MAP_RESET = 8'hF8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PORTS-1:0]         req_valid,
  input  logic [3*NUM_PORTS-1:0]       req_tc,
  input  logic                         map_wr_en,
  input  logic [7:0]                   map_wr_data,
  input  logic [1:0]                   crd_ret_en,
  input  logic [2*RET_W-1:0]           crd_ret_amt,
  input  logic                         gnt_ready,
  output logic                         gnt_valid,
  output logic [$clog2(NUM_PORTS)-1:0] gnt_port,
  output logic                         gnt_vc
);

  localparam int PW = $clog2(NUM_PORTS);
  localparam int SW = CREDIT_W + 1;
  localparam logic [CREDIT_W-1:0] CRD_MAX = '1;

  logic [7:0]                 tc_map;
  logic [1:0][CREDIT_W-1:0]   crd_q;
  logic [1:0][CREDIT_W-1:0]   crd_nxt;
  logic [1:0][PW-1:0]         ptr_q;
  logic [1:0][NUM_PORTS-1:0]  vc_req;
  logic [1:0][PW-1:0]         vc_win;
  logic [1:0]                 vc_elig;
  logic                       hs;

  always_comb begin
    vc_req = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      vc_req[tc_map[req_tc[3*p +: 3]]][p] = req_valid[p];
    end
  end

  for (genvar v = 0; v < 2; v++) begin : g_vc
    logic [PW-1:0] win_c;
    logic          found;
    logic [SW-1:0] sum;
    logic          take;

    always_comb begin
      found = 1'b0;
      win_c = ptr_q[v];
      for (int i = 0; i < NUM_PORTS; i++) begin
        logic [PW-1:0] idx;
        idx = PW'((int'(ptr_q[v]) + i) % NUM_PORTS);
        if (!found && vc_req[v][idx]) begin
          found = 1'b1;
          win_c = idx;
        end
      end
    end

    assign vc_win[v]  = win_c;
    assign vc_elig[v] = found && (crd_q[v] != '0);
    assign take       = hs && (gnt_vc == 1'(v));

    always_comb begin
      sum = SW'(crd_q[v]) - SW'(take);
      if (crd_ret_en[v]) sum = sum + SW'(crd_ret_amt[RET_W*v +: RET_W]);
      crd_nxt[v] = sum[CREDIT_W] ? CRD_MAX : sum[CREDIT_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr_q[v] <= '0;
        crd_q[v] <= '0;
      end else begin
        crd_q[v] <= crd_nxt[v];
        if (take) ptr_q[v] <= PW'((int'(win_c) + 1) % NUM_PORTS);
      end
    end
  end

  assign gnt_vc    = vc_elig[1];
  assign gnt_valid = |vc_elig;
  assign gnt_port  = vc_win[gnt_vc];
  assign hs        = gnt_valid && gnt_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)         tc_map <= MAP_RESET;
    else if (map_wr_en) tc_map <= map_wr_data;
  end

endmodule

// File: rtl/tc_vc_egress_arb_chk.sv
module tc_vc_egress_arb_chk #(
  parameter int NUM_PORTS = 4,
  parameter int CREDIT_W  = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_PORTS-1:0]         req_valid,
  input logic [3*NUM_PORTS-1:0]       req_tc,
  input logic                         map_wr_en,
  input logic [7:0]                   map_wr_data,
  input logic [1:0]                   crd_ret_en,
  input logic                         gnt_ready,
  input logic                         gnt_valid,
  input logic [$clog2(NUM_PORTS)-1:0] gnt_port,
  input logic                         gnt_vc,
  input logic [7:0]                   tc_map,
  input logic [1:0][CREDIT_W-1:0]     crd
);

  logic vc1_ready;
  always_comb begin
    vc1_ready = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (req_valid[p] && tc_map[req_tc[3*p +: 3]]) vc1_ready = 1'b1;
    vc1_ready = vc1_ready && (crd[1] != '0);
  end

  AST_GNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (req_valid[gnt_port] && (tc_map[req_tc[3*gnt_port +: 3]] == gnt_vc))); // R2
  AST_CRD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (crd[gnt_vc] != '0)); // R7
  AST_VC1_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_vc) |-> !vc1_ready); // R6
  AST_CRD_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_ready && !gnt_vc && !crd_ret_en[0]) |=> (crd[0] == CREDIT_W'($past(crd[0]) - 1'b1))); // R8
  AST_NO_HS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(gnt_valid && gnt_ready) && !crd_ret_en[1]) |=> $stable(crd[1])); // R5
  AST_MAP_WR: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr_en |=> (tc_map == $past(map_wr_data))); // R3
  AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |-> !gnt_valid); // R10

endmodule

bind tc_vc_egress_arb tc_vc_egress_arb_chk #(.NUM_PORTS(NUM_PORTS), .CREDIT_W(CREDIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tc(req_tc),
  .map_wr_en(map_wr_en), .map_wr_data(map_wr_data), .crd_ret_en(crd_ret_en),
  .gnt_ready(gnt_ready), .gnt_valid(gnt_valid), .gnt_port(gnt_port),
  .gnt_vc(gnt_vc), .tc_map(tc_map), .crd(crd_q)
);

// File: tb/tc_vc_egress_arb_tb.sv
`timescale 1ns/1ps
module tc_vc_egress_arb_tb;
  localparam int N = 4;
  localparam int CMAX = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_valid = '0;
  logic [3*N-1:0] req_tc = '0;
  logic map_wr_en = 1'b0;
  logic [7:0] map_wr_data = '0;
  logic [1:0] crd_ret_en = '0;
  logic [7:0] crd_ret_amt = '0;
  logic gnt_ready = 1'b0;
  logic gnt_valid;
  logic [1:0] gnt_port;
  logic gnt_vc;

  int checks = 0;
  int fails = 0;
  logic [7:0] m_map;
  int m_crd[2];
  int m_ptr[2];

  always #2 clk = ~clk;

  tc_vc_egress_arb #(.NUM_PORTS(N), .CREDIT_W(6), .RET_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tc(req_tc),
    .map_wr_en(map_wr_en), .map_wr_data(map_wr_data), .crd_ret_en(crd_ret_en),
    .crd_ret_amt(crd_ret_amt), .gnt_ready(gnt_ready), .gnt_valid(gnt_valid),
    .gnt_port(gnt_port), .gnt_vc(gnt_vc)
  );

  task automatic step(input logic [3:0] rv, input logic [11:0] tcs, input logic rdy,
                      input logic [1:0] ren, input logic [7:0] ramt,
                      input logic mwe, input logic [7:0] mwd, input string tag);
    logic [1:0] el;
    int win[2];
    int ev, ew;
    logic evalid;
    @(negedge clk);
    req_valid = rv; req_tc = tcs; gnt_ready = rdy; crd_ret_en = ren;
    crd_ret_amt = ramt; map_wr_en = mwe; map_wr_data = mwd;
    #1;
    for (int v = 0; v < 2; v++) begin
      el[v] = 1'b0;
      win[v] = 0;
      for (int i = 0; i < N; i++) begin
        int p;
        p = (m_ptr[v] + i) % N;
        if (!el[v] && rv[p] && (int'(m_map[tcs[3*p +: 3]]) == v)) begin
          el[v] = 1'b1;
          win[v] = p;
        end
      end
      el[v] = el[v] && (m_crd[v] > 0);
    end
    evalid = el[0] | el[1];
    ev = el[1] ? 1 : 0;
    ew = win[ev];
    checks++;
    if (gnt_valid !== evalid ||
        (evalid && (int'(gnt_vc) != ev || int'(gnt_port) != ew))) begin
      fails++;
      $display("FAIL %s: valid/vc/port actual %0b/%0d/%0d expected %0b/%0d/%0d",
               tag, gnt_valid, gnt_vc, gnt_port, evalid, ev, ew);
    end
    for (int v = 0; v < 2; v++) begin
      int c;
      c = m_crd[v];
      if (evalid && rdy && ev == v) begin
        c = c - 1;
        m_ptr[v] = (ew + 1) % N;
      end
      if (ren[v]) c = c + int'(ramt[4*v +: 4]);
      m_crd[v] = (c > CMAX) ? CMAX : c;
    end
    if (mwe) m_map = mwd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] all0;
    m_map = 8'hF8; m_crd[0] = 0; m_crd[1] = 0; m_ptr[0] = 0; m_ptr[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: all ports request, no credit yet
    step(4'hF, 12'hFFF, 1'b1, 2'b00, 8'h00, 1'b0, 8'h00, "R1");
    step(4'hF, 12'h000, 1'b1, 2'b00, 8'h00, 1'b0, 8'h00, "R1");
    // R10: credit present, no requests
    step(4'h0, 12'h000, 1'b1, 2'b11, 8'hFF, 1'b0, 8'h00, "R10");
    // R2 sweep with ready low, R5 no consumption
    for (int t = 0; t < 8; t++)
      step(4'h1, 12'(t), 1'b0, 2'b00, 8'h00, 1'b0, 8'h00, "R2");
    for (int t = 0; t < 8; t++)
      step(4'h4, 12'(t << 6), 1'b0, 2'b00, 8'h00, 1'b0, 8'h00, "R5");
    // R3: write a new map; old map in the write cycle, new map next
    step(4'h1, 12'h000, 1'b0, 2'b00, 8'h00, 1'b1, 8'h0F, "R3");
    for (int t = 0; t < 8; t++)
      step(4'h1, 12'(t), 1'b0, 2'b00, 8'h00, 1'b0, 8'h00, "R3");
    step(4'h1, 12'h000, 1'b0, 2'b00, 8'h00, 1'b1, 8'hF8, "R3");
    step(4'h1, 12'h000, 1'b0, 2'b00, 8'h00, 1'b0, 8'h00, "R3");
    // R4: all ports on channel 0, rotating grants, ready sometimes low
    for (int k = 0; k < 12; k++)
      step(4'hF, 12'h000, (k % 3) != 2, 2'b00, 8'h00, 1'b0, 8'h00, "R4");
    step(4'hA, 12'h000, 1'b1, 2'b00, 8'h00, 1'b0, 8'h00, "R4");
    step(4'hA, 12'h000, 1'b1, 2'b00, 8'h00, 1'b0, 8'h00, "R4");
    // R6: both channels eligible
    all0 = {3'd7, 3'd0, 3'd5, 3'd1};
    for (int k = 0; k < 6; k++)
      step(4'hF, all0, 1'b1, 2'b00, 8'h00, 1'b0, 8'h00, "R6");
    // R7: drain channel 1 while channel 0 also requests
    for (int k = 0; k < 20; k++)
      step(4'hF, all0, 1'b1, 2'b00, 8'h00, 1'b0, 8'h00, "R7");
    // R8: return together with a grant, then drain and count
    step(4'h8, all0, 1'b1, 2'b10, 8'h30, 1'b0, 8'h00, "R8");
    step(4'h8, all0, 1'b1, 2'b10, 8'h20, 1'b0, 8'h00, "R8");
    for (int k = 0; k < 8; k++)
      step(4'h8, all0, 1'b1, 2'b00, 8'h00, 1'b0, 8'h00, "R8");
    // R9: overfill channel 1, then drain past the limit
    for (int k = 0; k < 6; k++)
      step(4'h0, all0, 1'b0, 2'b10, 8'hF0, 1'b0, 8'h00, "R9");
    for (int k = 0; k < 68; k++)
      step(4'h8, all0, 1'b1, 2'b00, 8'h00, 1'b0, 8'h00, "R9");
    // Mixed sweep exercising R4 and R6 together with map writes and returns
    for (int k = 0; k < 4000; k++)
      step(4'($urandom), 12'($urandom), ($urandom % 4) != 0,
           (($urandom % 3) == 0) ? 2'($urandom) : 2'b00, 8'($urandom),
           ($urandom % 50) == 0, 8'($urandom), "R4/R6");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule